// File: doc/BRIEF.md
# Transmit Descriptor Buffer Sequencer

This block receives one transmit descriptor that has already been fetched as four 32-bit words: a status word, a control word and two address words. It also receives the memory address the descriptor was read from. It decodes the control word and turns the descriptor into an ordered series of buffer read requests to a DMA read port. Each request carries an address and a byte count, and is held until the port accepts it. The block then reports where the next descriptor lives. That is either the address word that the control word marks as a chain pointer, or the descriptor that follows in memory.

A descriptor whose control word flags it as a setup descriptor is handled differently, and it never reaches the transmit datapath. The block first checks that it is valid. A valid one produces a single read request marked for the filter. The returned longwords are then written one at a time into the address-filter RAM, at word addresses counting up from zero. When the last word has been written, the two filter-type bits the descriptor carries are latched as the current filter mode. A setup descriptor that breaks any rule raises a one-cycle error pulse instead, and causes no reads and no writes.

Top module: `txds_top`

## Requirements
- R1: While `descReady` is high the block issues no read request and no filter write. A descriptor is taken on a cycle where `descValid` and `descReady` are both high, and `descReady` stays low until that descriptor has been fully processed.
- R2: For a non-setup descriptor, a nonzero control field [10:0] produces a read request with address `descBuf1Addr` and length equal to that field, with `reqToFilter` low. If the field is zero, buffer 1 is skipped.
- R3: When control bit 24 is clear and control field [21:11] is nonzero, a read request with address `descBuf2Addr` and that length follows the buffer 1 request (or is the only request if buffer 1 is skipped). If the field is zero, no second request is made.
- R4: When control bit 24 is set, no second buffer is read, whatever field [21:11] holds, and `nextDescAddr` equals `descBuf2Addr`. When bit 24 is clear, `nextDescAddr` equals `descAddr` + 16.
- R5: A read request keeps `reqValid`, `reqAddr`, `reqLen` and `reqToFilter` unchanged until the cycle in which `reqReady` is high.
- R6: Control bit 27 marks a setup descriptor. It is valid only when all of these hold: control field [10:0] equals 192; `descBuf1Addr[1:0]` is 00; control bits 29 and 30 are both clear; the second buffer is unused (bit 24 set, or field [21:11] zero); and `engineStopped` was high when the descriptor was taken. A valid one produces exactly one request, with address `descBuf1Addr`, length 192 and `reqToFilter` high.
- R7: After a valid setup request has been accepted, each cycle with `rdValid` high writes `rdData` to the filter RAM. `filtAddr` runs 0, 1, … up to 47, 48 writes in total. `rdValid` at any other time causes no write.
- R8: `filtMode` becomes {status bit 28, control bit 22} one cycle after the 48th filter write. It keeps its old value during all writes, and it is never changed by a non-setup descriptor or a rejected setup descriptor.
- R9: An invalid setup descriptor gives a one-cycle `setupErr` pulse, followed directly by the next-descriptor pulse. It causes no read request, no filter write and no change to `filtMode`.
- R10: Every descriptor ends with exactly one one-cycle `nextDescValid` pulse, after all of its requests, writes or its error. `descReady` is high in the following cycle.
- R11: After reset, `descReady` is high, `filtMode` is 00, and `reqValid`, `filtWe`, `setupErr` and `nextDescValid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descValid | input | 1 | A descriptor is presented |
| descReady | output | 1 | Sequencer is idle and takes a descriptor |
| descAddr | input | 32 | Memory address of the presented descriptor |
| descWord0 | input | 32 | Status word (bit 28 is the upper filter-type bit) |
| descCtrl | input | 32 | Control word |
| descBuf1Addr | input | 32 | Buffer 1 address word |
| descBuf2Addr | input | 32 | Buffer 2 address or chain pointer |
| engineStopped | input | 1 | Transmit engine is in its stopped state |
| reqValid | output | 1 | Read request valid |
| reqReady | input | 1 | DMA read port accepts the request |
| reqAddr | output | 32 | Request byte address |
| reqLen | output | 11 | Request byte count |
| reqToFilter | output | 1 | Request data goes to the filter RAM, not the transmit path |
| rdValid | input | 1 | Read data longword valid |
| rdData | input | 32 | Read data longword |
| filtWe | output | 1 | Filter RAM write enable |
| filtAddr | output | 6 | Filter RAM word address |
| filtData | output | 32 | Filter RAM write data |
| filtMode | output | 2 | Latched filter mode {upper, lower} |
| nextDescValid | output | 1 | Descriptor finished; next address valid |
| nextDescAddr | output | 32 | Address of the next descriptor |
| setupErr | output | 1 | Invalid setup descriptor pulse |

## Verification
The assertions make four assumptions about the inputs. The DMA port may hold `reqReady` low for any number of cycles. Descriptor inputs matter only in the cycle in which the descriptor is taken. `rdValid` may be pulsed at any time. A setup fill is supplied with exactly as many longwords as the payload holds. The stimulus keeps to these assumptions in the following way. `reqReady` follows a repeating pattern that stalls every third cycle. Descriptor words change only at the handshake. The 48 setup longwords are sent, with idle gaps, only once the filter request has been accepted. Stray `rdValid` pulses are sent while the block is idle.

// File: rtl/txds_pkg.sv
package txds_pkg;
  localparam int WORD_W    = 32;
  localparam int SIZE_W    = 11;
  // control-word field positions (decoded by this block)
  localparam int B1_LSB    = 0;
  localparam int B2_LSB    = 11;
  localparam int BIT_FT0   = 22;
  localparam int BIT_CHAIN = 24;
  localparam int BIT_SETUP = 27;
  localparam int BIT_FIRST = 29;
  localparam int BIT_LAST  = 30;
  // status-word position
  localparam int BIT_FT1   = 28;

  typedef enum logic [3:0] {
    S_IDLE, S_DECODE, S_BUF1, S_BUF2, S_SREQ, S_SFILL, S_SLATCH, S_ERR, S_NEXT
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic selBuf2;
    logic fillWrite;
    logic latchMode;
    logic clrCount;
  } dpStrobe_t;

  typedef struct packed {
    logic isSetup;
    logic setupOk;
    logic buf1Use;
    logic buf2Use;
    logic fillLast;
  } dpFlag_t;
endpackage

// File: rtl/txds_datapath.sv
module txds_datapath
  import txds_pkg::*;
#(
  parameter int SETUP_BYTES = 192,
  parameter int DESC_BYTES  = 16,
  localparam int FILL_WORDS = SETUP_BYTES / 4,
  localparam int CNT_W      = $clog2(FILL_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [WORD_W-1:0] descAddr,
  input  logic [WORD_W-1:0] descWord0,
  input  logic [WORD_W-1:0] descCtrl,
  input  logic [WORD_W-1:0] descBuf1Addr,
  input  logic [WORD_W-1:0] descBuf2Addr,
  input  logic              engineStopped,
  input  logic [WORD_W-1:0] rdData,
  output dpFlag_t           flags,
  output logic [WORD_W-1:0] reqAddr,
  output logic [SIZE_W-1:0] reqLen,
  output logic              filtWe,
  output logic [CNT_W-1:0]  filtAddr,
  output logic [WORD_W-1:0] filtData,
  output logic [1:0]        filtMode,
  output logic [WORD_W-1:0] nextDescAddr
);
  localparam logic [SIZE_W-1:0] SETUP_LEN  = SIZE_W'(SETUP_BYTES);
  localparam logic [CNT_W-1:0]  LAST_WORD  = CNT_W'(FILL_WORDS - 1);
  localparam logic [WORD_W-1:0] DESC_STEP  = WORD_W'(DESC_BYTES);

  logic [SIZE_W-1:0] size1Q, size2Q;
  logic              ft0Q, ft1Q, chainQ, setupQ, firstQ, lastQ, stoppedQ;
  logic [WORD_W-1:0] addr1Q, addr2Q, baseQ;
  logic [CNT_W-1:0]  fillCnt;
  logic [1:0]        modeQ;
  logic              unusedBits;

  assign unusedBits = ^{descCtrl[31], descCtrl[26:25], descCtrl[23],
                        descWord0[31:29], descWord0[27:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      size1Q <= '0; size2Q <= '0;
      ft0Q <= 1'b0; ft1Q <= 1'b0; chainQ <= 1'b0; setupQ <= 1'b0;
      firstQ <= 1'b0; lastQ <= 1'b0; stoppedQ <= 1'b0;
      addr1Q <= '0; addr2Q <= '0; baseQ <= '0;
    end else if (strobes.capture) begin
      size1Q   <= descCtrl[B1_LSB +: SIZE_W];
      size2Q   <= descCtrl[B2_LSB +: SIZE_W];
      ft0Q     <= descCtrl[BIT_FT0];
      chainQ   <= descCtrl[BIT_CHAIN];
      setupQ   <= descCtrl[BIT_SETUP];
      firstQ   <= descCtrl[BIT_FIRST];
      lastQ    <= descCtrl[BIT_LAST];
      ft1Q     <= descWord0[BIT_FT1];
      stoppedQ <= engineStopped;
      addr1Q   <= descBuf1Addr;
      addr2Q   <= descBuf2Addr;
      baseQ    <= descAddr;
    end
  end

  // fill counter doubles as the filter RAM word address
  always_ff @(posedge clk) begin
    if (!rstN) fillCnt <= '0;
    else if (strobes.clrCount) fillCnt <= '0;
    else if (strobes.fillWrite) fillCnt <= fillCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= 2'b00;
    else if (strobes.latchMode) modeQ <= {ft1Q, ft0Q};
  end

  always_comb begin
    flags.isSetup  = setupQ;
    flags.buf1Use  = (size1Q != '0);
    flags.buf2Use  = !chainQ && (size2Q != '0);
    flags.setupOk  = stoppedQ && (size1Q == SETUP_LEN) && (addr1Q[1:0] == 2'b00)
                     && !firstQ && !lastQ && !flags.buf2Use;
    flags.fillLast = (fillCnt == LAST_WORD);
  end

  assign reqAddr      = strobes.selBuf2 ? addr2Q : addr1Q;
  assign reqLen       = strobes.selBuf2 ? size2Q : size1Q;
  assign filtWe       = strobes.fillWrite;
  assign filtAddr     = fillCnt;
  assign filtData     = rdData;
  assign filtMode     = modeQ;
  assign nextDescAddr = chainQ ? addr2Q : baseQ + DESC_STEP;
endmodule

// File: rtl/txds_ctrl.sv
module txds_ctrl
  import txds_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      descValid,
  input  logic      reqReady,
  input  logic      rdValid,
  input  dpFlag_t   flags,
  output dpStrobe_t strobes,
  output logic      descReady,
  output logic      reqValid,
  output logic      reqToFilter,
  output logic      nextDescValid,
  output logic      setupErr
);
  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else state <= stateNext;
  end

  always_comb begin
    stateNext     = state;
    strobes       = '0;
    descReady     = 1'b0;
    reqValid      = 1'b0;
    reqToFilter   = 1'b0;
    nextDescValid = 1'b0;
    setupErr      = 1'b0;
    unique case (state)
      S_IDLE: begin
        descReady = 1'b1;
        if (descValid) begin
          strobes.capture  = 1'b1;
          strobes.clrCount = 1'b1;
          stateNext        = S_DECODE;
        end
      end
      S_DECODE: begin
        if (flags.isSetup) stateNext = flags.setupOk ? S_SREQ : S_ERR;
        else if (flags.buf1Use) stateNext = S_BUF1;
        else if (flags.buf2Use) stateNext = S_BUF2;
        else stateNext = S_NEXT;
      end
      S_BUF1: begin
        reqValid = 1'b1;
        if (reqReady) stateNext = flags.buf2Use ? S_BUF2 : S_NEXT;
      end
      S_BUF2: begin
        reqValid        = 1'b1;
        strobes.selBuf2 = 1'b1;
        if (reqReady) stateNext = S_NEXT;
      end
      S_SREQ: begin
        reqValid    = 1'b1;
        reqToFilter = 1'b1;
        if (reqReady) stateNext = S_SFILL;
      end
      S_SFILL: begin
        if (rdValid) begin
          strobes.fillWrite = 1'b1;
          if (flags.fillLast) stateNext = S_SLATCH;
        end
      end
      S_SLATCH: begin
        strobes.latchMode = 1'b1;
        strobes.clrCount  = 1'b1;
        stateNext         = S_NEXT;
      end
      S_ERR: begin
        setupErr  = 1'b1;
        stateNext = S_NEXT;
      end
      S_NEXT: begin
        nextDescValid = 1'b1;
        stateNext     = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end
endmodule

// File: rtl/txds_top.sv
module txds_top
  import txds_pkg::*;
#(
  parameter int SETUP_BYTES = 192,
  parameter int DESC_BYTES  = 16,
  localparam int FILL_WORDS = SETUP_BYTES / 4,
  localparam int CNT_W      = $clog2(FILL_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descValid,
  output logic              descReady,
  input  logic [WORD_W-1:0] descAddr,
  input  logic [WORD_W-1:0] descWord0,
  input  logic [WORD_W-1:0] descCtrl,
  input  logic [WORD_W-1:0] descBuf1Addr,
  input  logic [WORD_W-1:0] descBuf2Addr,
  input  logic              engineStopped,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [WORD_W-1:0] reqAddr,
  output logic [SIZE_W-1:0] reqLen,
  output logic              reqToFilter,
  input  logic              rdValid,
  input  logic [WORD_W-1:0] rdData,
  output logic              filtWe,
  output logic [CNT_W-1:0]  filtAddr,
  output logic [WORD_W-1:0] filtData,
  output logic [1:0]        filtMode,
  output logic              nextDescValid,
  output logic [WORD_W-1:0] nextDescAddr,
  output logic              setupErr
);
  dpStrobe_t strobes;
  dpFlag_t   flags;

  txds_ctrl u_ctrl (
    .clk, .rstN, .descValid, .reqReady, .rdValid, .flags, .strobes,
    .descReady, .reqValid, .reqToFilter, .nextDescValid, .setupErr
  );

  txds_datapath #(.SETUP_BYTES(SETUP_BYTES), .DESC_BYTES(DESC_BYTES)) u_dp (
    .clk, .rstN, .strobes, .descAddr, .descWord0, .descCtrl, .descBuf1Addr,
    .descBuf2Addr, .engineStopped, .rdData, .flags, .reqAddr, .reqLen,
    .filtWe, .filtAddr, .filtData, .filtMode, .nextDescAddr
  );
endmodule

// File: rtl/txds_checker.sv
module txds_checker #(
  parameter int SETUP_BYTES = 192,
  localparam int FILL_WORDS = SETUP_BYTES / 4,
  localparam int CNT_W      = $clog2(FILL_WORDS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             descReady,
  input logic             reqValid,
  input logic             reqReady,
  input logic [31:0]      reqAddr,
  input logic [10:0]      reqLen,
  input logic             reqToFilter,
  input logic             filtWe,
  input logic [CNT_W-1:0] filtAddr,
  input logic [1:0]       filtMode,
  input logic             nextDescValid,
  input logic             setupErr
);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(FILL_WORDS - 1);
  localparam logic [10:0]      SETUP_LEN = 11'(SETUP_BYTES);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    descReady |-> !reqValid && !filtWe);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqLen)
                              && $stable(reqToFilter));

  assert_setup_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqToFilter |-> reqLen == SETUP_LEN && reqAddr[1:0] == 2'b00);

  assert_fill_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    filtWe |=> filtAddr == $past(filtAddr) + 1'b1);

  assert_mode_after_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtMode) |-> $past(filtWe, 2) && $past(filtAddr, 2) == LAST_WORD);

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    setupErr |=> !setupErr && nextDescValid);

  assert_next_then_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    nextDescValid |=> descReady && !nextDescValid);
endmodule

bind txds_top txds_checker #(.SETUP_BYTES(SETUP_BYTES)) u_chk (
  .clk, .rstN, .descReady, .reqValid, .reqReady, .reqAddr, .reqLen,
  .reqToFilter, .filtWe, .filtAddr, .filtMode, .nextDescValid, .setupErr
);

// File: tb/txds_top_bench.sv
module txds_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SBYTES     = 192;
  localparam int NWORDS     = SBYTES / 4;
  localparam int K_REQ = 0, K_NEXT = 1, K_ERR = 2, K_WR = 3;

  typedef struct {
    int          kind;
    logic [31:0] addr;
    logic [10:0] len;
    logic        flag;
    logic [31:0] data;
    logic [1:0]  mode;
    string       tag;
  } item_t;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        descValid = 1'b0, engineStopped = 1'b0, reqReady = 1'b0, rdValid = 1'b0;
  logic [31:0] descAddr = '0, descWord0 = '0, descCtrl = '0, descBuf1Addr = '0,
               descBuf2Addr = '0, rdData = '0;
  logic        descReady, reqValid, reqToFilter, filtWe, nextDescValid, setupErr;
  logic [31:0] reqAddr, filtData, nextDescAddr;
  logic [10:0] reqLen;
  logic [5:0]  filtAddr;
  logic [1:0]  filtMode;

  item_t       expQ[$];
  int          nChecks = 0, nFails = 0, doneCnt = 0, cyc = 0;
  logic        setupSeen = 1'b0;
  logic [1:0]  expMode = 2'b00;

  txds_top u_txds_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wordOf(input int i);
    return {16'hC0DE, 16'(i * 7 + 3)};
  endfunction

  function automatic item_t mk(input int k, input logic [31:0] a, input logic [10:0] l,
                               input logic f, input logic [31:0] d, input logic [1:0] m,
                               input string t);
    item_t it;
    it.kind = k; it.addr = a; it.len = l; it.flag = f; it.data = d; it.mode = m; it.tag = t;
    return it;
  endfunction

  // reqReady pattern: stalls every third cycle
  always @(negedge clk) begin
    cyc++;
    reqReady <= (cyc % 3 != 1);
  end

  // monitor: sample away from the active edge, after the drivers have settled
  always begin
    @(negedge clk);
    #1;
    if (rstN) begin
      int  k;
      bit  ev;
      ev = 1'b1;
      if (reqValid && reqReady) k = K_REQ;
      else if (nextDescValid) k = K_NEXT;
      else if (setupErr) k = K_ERR;
      else if (filtWe) k = K_WR;
      else ev = 1'b0;
      if (ev) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1", "unexpected event kind", 64'(k), 64'hFFFF);
        end else begin
          item_t e;
          e = expQ.pop_front();
          check(e.kind == k, e.tag, "event kind", 64'(k), 64'(e.kind));
          if (e.kind == k) begin
            case (k)
              K_REQ: begin
                check(reqAddr == e.addr, e.tag, "reqAddr", 64'(reqAddr), 64'(e.addr));
                check(reqLen == e.len, e.tag, "reqLen", 64'(reqLen), 64'(e.len));
                check(reqToFilter == e.flag, e.tag, "reqToFilter", 64'(reqToFilter), 64'(e.flag));
                if (reqToFilter) setupSeen = 1'b1;
              end
              K_NEXT: begin
                check(nextDescAddr == e.addr, e.tag, "nextDescAddr", 64'(nextDescAddr), 64'(e.addr));
                check(filtMode == e.mode, "R8", "filtMode at end", 64'(filtMode), 64'(e.mode));
                doneCnt++;
              end
              K_ERR: check(filtMode == e.mode, "R9", "filtMode at error", 64'(filtMode), 64'(e.mode));
              default: begin
                check(filtAddr == e.addr[5:0], "R7", "filtAddr", 64'(filtAddr), 64'(e.addr));
                check(filtData == e.data, "R7", "filtData", 64'(filtData), 64'(e.data));
                check(filtMode == e.mode, "R8", "filtMode during fill", 64'(filtMode), 64'(e.mode));
              end
            endcase
          end
        end
      end
    end
  end

  task automatic noise(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rdValid = 1'b1; rdData = 32'hDEAD0000 | 32'(i);
    end
    @(negedge clk); rdValid = 1'b0;
  endtask

  task automatic runDesc(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2,
                         input logic [31:0] w3, input logic [31:0] da, input logic stopped);
    logic       setup, chain, b2, ok;
    logic [10:0] s1, s2;
    int          target;
    setup = w1[27]; chain = w1[24]; s1 = w1[10:0]; s2 = w1[21:11];
    b2 = !chain && (s2 != 0);
    ok = 1'b0;
    if (setup) begin
      ok = stopped && (s1 == 11'(SBYTES)) && (w2[1:0] == 2'b00) && !w1[29] && !w1[30] && !b2;
      if (ok) begin
        expQ.push_back(mk(K_REQ, w2, 11'(SBYTES), 1'b1, '0, expMode, "R6"));
        for (int i = 0; i < NWORDS; i++)
          expQ.push_back(mk(K_WR, 32'(i), '0, 1'b0, wordOf(i), expMode, "R7"));
        expMode = {w0[28], w1[22]};
      end else begin
        expQ.push_back(mk(K_ERR, '0, '0, 1'b0, '0, expMode, "R9"));
      end
    end else begin
      if (s1 != 0) expQ.push_back(mk(K_REQ, w2, s1, 1'b0, '0, expMode, "R2"));
      if (b2) expQ.push_back(mk(K_REQ, w3, s2, 1'b0, '0, expMode, "R3"));
    end
    expQ.push_back(mk(K_NEXT, chain ? w3 : da + 32'd16, '0, 1'b0, '0, expMode,
                      chain ? "R4" : "R10"));
    target = doneCnt + 1;
    setupSeen = 1'b0;
    do @(negedge clk); while (!descReady);
    descValid = 1'b1; descWord0 = w0; descCtrl = w1; descBuf1Addr = w2;
    descBuf2Addr = w3; descAddr = da; engineStopped = stopped;
    @(negedge clk);
    descValid = 1'b0; descCtrl = 32'hFFFF_FFFF; descBuf1Addr = 32'h0BAD_0BAD;
    check(!descReady, "R1", "descReady after accept", 64'(descReady), 64'd0);
    if (ok) begin
      while (!setupSeen) @(negedge clk);
      for (int i = 0; i < NWORDS; i++) begin
        @(negedge clk); rdValid = 1'b1; rdData = wordOf(i);
        if (i % 3 == 2) begin @(negedge clk); rdValid = 1'b0; end
      end
      @(negedge clk); rdValid = 1'b0;
    end
    while (doneCnt < target) @(negedge clk);
    @(negedge clk); #2;
    check(descReady == 1'b1, "R10", "descReady after next pulse", 64'(descReady), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    check(descReady == 1'b1, "R11", "reset descReady", 64'(descReady), 64'd1);
    check(!reqValid && !filtWe && !setupErr && !nextDescValid, "R11", "reset strobes",
          64'({reqValid, filtWe, setupErr, nextDescValid}), 64'd0);
    check(filtMode == 2'b00, "R11", "reset filtMode", 64'(filtMode), 64'd0);
    noise(4);  // R7: rdValid while idle writes nothing
    // R2 R3: both buffers; mode bits present but not setup -> R8 unchanged
    runDesc(32'h1000_0000, (32'd37 << 11) | 32'd100 | (32'h1 << 22), 32'h1000_0003,
            32'h2000_0001, 32'h0000_0400, 1'b0);
    // R2 skip buffer 1
    runDesc('0, (32'd64 << 11), 32'h1111_0000, 32'h2222_0002, 32'h0000_0800, 1'b1);
    // R3 buffer 2 size zero
    runDesc('0, 32'd50, 32'h3333_0001, 32'h4444_0000, 32'h0000_0C00, 1'b0);
    // R4 chained: second size ignored
    runDesc('0, (32'h1 << 24) | (32'd99 << 11) | 32'd20, 32'h5555_0005, 32'h6666_0040,
            32'h0000_1000, 1'b0);
    // R10 both sizes zero
    runDesc('0, 32'd0, 32'h7777_0000, 32'h8888_0000, 32'h0000_1400, 1'b0);
    noise(3);
    // R6 valid setup, mode {1,0}
    runDesc(32'h1 << 28, (32'h1 << 27) | 32'd192, 32'h3000_0100, 32'h0, 32'h0000_2000, 1'b1);
    // R9 invalid setups
    runDesc('0, (32'h1 << 27) | (32'h1 << 22) | 32'd188, 32'h3000_0100, '0, 32'h0000_2400, 1'b1);
    runDesc('0, (32'h1 << 27) | (32'h1 << 22) | 32'd192, 32'h3000_0102, '0, 32'h0000_2800, 1'b1);
    runDesc('0, (32'h1 << 27) | (32'h1 << 29) | 32'd192, 32'h3000_0100, '0, 32'h0000_2C00, 1'b1);
    runDesc('0, (32'h1 << 27) | (32'h1 << 30) | 32'd192, 32'h3000_0100, '0, 32'h0000_3000, 1'b1);
    runDesc('0, (32'h1 << 27) | (32'h1 << 22) | 32'd192, 32'h3000_0100, '0, 32'h0000_3400, 1'b0);
    runDesc('0, (32'h1 << 27) | (32'd8 << 11) | 32'd192, 32'h3000_0100, 32'h10, 32'h0000_3800, 1'b1);
    // R6 R4 valid chained setup, mode {0,1}
    runDesc('0, (32'h1 << 27) | (32'h1 << 24) | (32'h1 << 22) | (32'd5 << 11) | 32'd192,
            32'h4000_0200, 32'h9000_0000, 32'h0000_3C00, 1'b1);
    noise(2);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R10", "pending expected events", 64'(expQ.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFails++;
    $display("FAIL R10 watchdog expired: actual %0d expected %0d", doneCnt, 13);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule